// File: doc/BRIEF.md
# I2C Slave Own-Address Matcher

This block keeps the slave address that an I2C controller answers to and decides, one byte at a time, whether the bus has called it. A host programs the address over a small parallel register port. The serial side hands over each received byte on a valid/ready stream. The block compares the first byte after a start condition with the stored address. If they match, it raises an addressed-as-slave flag.

The stored value is seven bits wide and is compared one position higher than it is stored. Stored bit i is matched against received bit i+1, and received bit 0 (the read/write direction) is never compared. So a stored 55h answers to bus bytes AAh and ABh. After reset the stored address is zero. That value is reported as monitor mode, in which the block listens but never claims the bus.

The host port has a select line. With the select line high, the port reaches the control register. With it low, the port reaches either the own-address register or the received-data register, chosen by the control register's setup bit. Initialization software writes the own-address register once, even if slave operation is never used.

The byte stream follows the usual valid/ready rule. A byte is taken in a cycle where `addr_valid` and `addr_ready` are both high. `addr_ready` is low only in a cycle in which the host writes the own-address register, so a compare never sees a half-updated address. The sender holds `addr_valid` and `addr_byte` steady until the byte is taken.

Top module: `i2c_own_addr_match`

## Requirements
- R1: After reset the own address is 00h, `aas` is 0, `monitor_mode` is 1, the setup bit is 0 and the received-data register is 00h.
- R2: A host write with `host_sel`=0 while the setup bit is 1 stores `host_wdata[6:0]` as the own address and ignores bit 7. A read in the same mode returns {1'b0, own[6:0]} combinationally.
- R3: When the first byte accepted after a start has bits [7:1] equal to the own address, `aas` becomes 1. Bit 0 of the byte does not take part, so own 55h matches AAh and ABh.
- R4: Only the first accepted byte after a start is compared. Later bytes, and bytes accepted with no start since the last compare or stop, leave `aas` unchanged.
- R5: A `bus_start` or `bus_stop` pulse clears `aas` on the next edge. A byte accepted in the same cycle as either pulse is not compared.
- R6: A read with `host_sel`=0 while the setup bit is 0 returns the last accepted byte and clears `aas` on the next edge. If a matching compare happens in that same cycle, the set wins.
- R7: `monitor_mode` is 1 exactly when the own address is 00h. While it is 1, no compare sets `aas`.
- R8: `addr_ready` is 0 in any cycle that writes the own-address register, and no byte is accepted in that cycle. It is 1 in every other cycle.
- R9: A host write with `host_sel`=1 stores `host_wdata[0]` as the setup bit. A read with `host_sel`=1 returns {5'b0, monitor_mode, aas, setup} in bits 7..0.
- R10: `aas` changes on the first clock edge after the accepting cycle, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 1 | 1 = control/status, 0 = own-address or data register |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| addr_valid | input | 1 | Received byte available |
| addr_ready | output | 1 | Block can take the byte |
| addr_byte | input | 8 | Received byte from the shift register |
| bus_start | input | 1 | Start condition pulse |
| bus_stop | input | 1 | Stop condition pulse |
| aas | output | 1 | Addressed-as-slave flag |
| monitor_mode | output | 1 | Own address is zero |

## Verification
Each register write, byte acceptance, start, stop and data-register read takes effect at the one clock edge that ends its cycle. Results are therefore due one cycle after the stimulus, while read data and `addr_ready` are combinational in the stimulus cycle. The bench drives every input just after a falling edge. It samples combinational results shortly after driving them, and registered results at the next falling edge, which is half a period after the edge that updates them. The corner tests place a start and a byte in the same cycle, a read and a matching byte in the same cycle, and an own-address write against a pending byte, so that each cycle-level priority is observed directly.

// File: rtl/oa_pkg.sv
package oa_pkg;
  localparam int unsigned OA_ADDR_W = 7;
  localparam int unsigned OA_BYTE_W = OA_ADDR_W + 1;

  typedef enum logic [1:0] {
    RSEL_CTRL = 2'd0,
    RSEL_OWN  = 2'd1,
    RSEL_DATA = 2'd2
  } rsel_e;

  function automatic rsel_e decode_sel(input logic sel_hi, input logic setup);
    if (sel_hi)     return RSEL_CTRL;
    else if (setup) return RSEL_OWN;
    else            return RSEL_DATA;
  endfunction
endpackage

// File: rtl/oa_host_regs.sv
module oa_host_regs
  import oa_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned BYTE_W = ADDR_W + 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_sel,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic              rx_take,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              aas_q,
  output logic [ADDR_W-1:0] own_q,
  output logic              setup_q,
  output logic              monitor,
  output logic              own_wr,
  output logic              data_rd,
  output logic [BYTE_W-1:0] rdata
);
  rsel_e              sel;
  logic [BYTE_W-1:0]  data_q;

  always_comb sel = decode_sel(host_sel, setup_q);

  assign own_wr  = host_wr && (sel == RSEL_OWN);
  assign data_rd = host_rd && (sel == RSEL_DATA);
  assign monitor = (own_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q   <= '0;
      setup_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (host_wr && sel == RSEL_CTRL) setup_q <= host_wdata[0];
      if (own_wr)                      own_q   <= host_wdata[ADDR_W-1:0];
      if (rx_take)                     data_q  <= rx_byte;
    end
  end

  always_comb begin
    rdata = '0;
    if (host_rd) begin
      unique case (sel)
        RSEL_CTRL: begin
          rdata[0] = setup_q;
          rdata[1] = aas_q;
          rdata[2] = monitor;
        end
        RSEL_OWN:  rdata[ADDR_W-1:0] = own_q;
        RSEL_DATA: rdata = data_q;
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/oa_addr_compare.sv
module oa_addr_compare #(
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned BYTE_W = ADDR_W + 1
)(
  input  logic [ADDR_W-1:0] own_q,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              monitor,
  output logic              hit
);
  logic [ADDR_W-1:0] bit_eq;

  // stored bit i lines up with received bit i+1; received bit 0 is R/W
  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign bit_eq[i] = (own_q[i] == rx_byte[i+1]);
  end

  assign hit = (&bit_eq) && !monitor;
endmodule

// File: rtl/oa_status.sv
module oa_status (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_take,
  input  logic hit,
  input  logic bus_start,
  input  logic bus_stop,
  input  logic data_rd,
  output logic aas_q
);
  logic armed_q;
  logic cond;
  logic compare;

  assign cond    = bus_start || bus_stop;
  assign compare = rx_take && armed_q && !cond;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      aas_q   <= 1'b0;
    end else begin
      if (bus_start)     armed_q <= 1'b1;
      else if (bus_stop) armed_q <= 1'b0;
      else if (rx_take)  armed_q <= 1'b0;

      if (cond)                 aas_q <= 1'b0;
      else if (compare && hit)  aas_q <= 1'b1;
      else if (data_rd)         aas_q <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_own_addr_match.sv
module i2c_own_addr_match
  import oa_pkg::*;
#(
  parameter int unsigned ADDR_W = OA_ADDR_W,
  localparam int unsigned BYTE_W = ADDR_W + 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_sel,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic              addr_valid,
  output logic              addr_ready,
  input  logic [BYTE_W-1:0] addr_byte,
  input  logic              bus_start,
  input  logic              bus_stop,
  output logic              aas,
  output logic              monitor_mode
);
  logic [ADDR_W-1:0] own_q;
  logic              setup_q;
  logic              own_wr;
  logic              data_rd;
  logic              rx_take;
  logic              hit;

  assign addr_ready = !own_wr;
  assign rx_take    = addr_valid && addr_ready;

  oa_host_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
    .host_wdata(host_wdata),
    .rx_take(rx_take), .rx_byte(addr_byte), .aas_q(aas),
    .own_q(own_q), .setup_q(setup_q), .monitor(monitor_mode),
    .own_wr(own_wr), .data_rd(data_rd), .rdata(host_rdata)
  );

  oa_addr_compare #(.ADDR_W(ADDR_W)) u_cmp (
    .own_q(own_q), .rx_byte(addr_byte), .monitor(monitor_mode), .hit(hit)
  );

  oa_status u_stat (
    .clk(clk), .rst_n(rst_n), .rx_take(rx_take), .hit(hit),
    .bus_start(bus_start), .bus_stop(bus_stop), .data_rd(data_rd),
    .aas_q(aas)
  );
endmodule

// File: rtl/i2c_own_addr_match_chk.sv
module i2c_own_addr_match_chk #(
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned BYTE_W = ADDR_W + 1
)(
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              host_sel,
  input logic [BYTE_W-1:0] host_wdata,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic              bus_start,
  input logic              bus_stop,
  input logic              aas,
  input logic              monitor_mode,
  input logic              setup_q
);
  assert_cond_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start || bus_stop) |=> !aas);

  assert_rise_needs_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aas) |-> $past(addr_valid && addr_ready));

  assert_monitor_never_claims_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aas) |-> !$past(monitor_mode));

  assert_monitor_follows_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_sel && setup_q) |=> (monitor_mode == ($past(host_wdata[ADDR_W-1:0]) == '0)));

  assert_ready_low_on_own_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_sel && setup_q) |-> !addr_ready);
endmodule

bind i2c_own_addr_match i2c_own_addr_match_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
  .host_wdata(host_wdata), .addr_valid(addr_valid), .addr_ready(addr_ready),
  .bus_start(bus_start), .bus_stop(bus_stop), .aas(aas),
  .monitor_mode(monitor_mode), .setup_q(setup_q)
);

// File: tb/i2c_own_addr_match_bench.sv
module i2c_own_addr_match_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_wr, host_rd, host_sel;
  logic [7:0] host_wdata, host_rdata;
  logic       addr_valid, addr_ready;
  logic [7:0] addr_byte;
  logic       bus_start, bus_stop, aas, monitor_mode;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  i2c_own_addr_match u_i2c_own_addr_match (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_byte(addr_byte),
    .bus_start(bus_start), .bus_stop(bus_stop), .aas(aas),
    .monitor_mode(monitor_mode)
  );

  // {own written, bus byte, expected aas}
  localparam logic [16:0] VEC [0:9] = '{
    {8'h55, 8'hAA, 1'b1}, {8'h55, 8'hAB, 1'b1}, {8'h55, 8'h54, 1'b0},
    {8'h7F, 8'hFE, 1'b1}, {8'h7F, 8'hFF, 1'b1}, {8'h01, 8'h02, 1'b1},
    {8'h01, 8'h82, 1'b0}, {8'h40, 8'h80, 1'b1}, {8'h40, 8'h81, 1'b1},
    {8'h00, 8'h00, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    host_wr = 0; host_rd = 0; host_sel = 0; host_wdata = 0;
    addr_valid = 0; addr_byte = 0; bus_start = 0; bus_stop = 0;
  endtask

  task automatic host_write(input logic sel, input logic [7:0] d);
    host_wr = 1; host_sel = sel; host_wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic host_read(input logic sel, output logic [7:0] d);
    host_rd = 1; host_sel = sel; #1 d = host_rdata;
    @(negedge clk); idle();
  endtask

  task automatic pulse_start();
    bus_start = 1; @(negedge clk); idle();
  endtask

  task automatic send(input logic [7:0] b);
    addr_valid = 1; addr_byte = b; @(negedge clk); idle();
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    idle(); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;

    // R1 reset state
    check("R1 aas", {7'b0, aas}, 8'h00);
    check("R1 monitor", {7'b0, monitor_mode}, 8'h01);
    host_read(1'b1, rd); check("R1/R9 status", rd, 8'h04);
    host_read(1'b0, rd); check("R1 data reg", rd, 8'h00);

    // table walk: R3 R7
    foreach (VEC[i]) begin
      host_write(1'b1, 8'h01);
      host_write(1'b0, VEC[i][16:9]);
      check("R7 monitor", {7'b0, monitor_mode}, {7'b0, VEC[i][16:9] == 8'h00});
      pulse_start();
      send(VEC[i][8:1]);
      check("R3 match", {7'b0, aas}, {7'b0, VEC[i][0]});
      bus_stop = 1; @(negedge clk); idle();
      check("R5 stop clears", {7'b0, aas}, 8'h00);
    end

    // R2 bit 7 ignored and readback
    host_write(1'b1, 8'h01);
    host_write(1'b0, 8'hD5);
    host_read(1'b0, rd); check("R2 own readback", rd, 8'h55);
    host_read(1'b1, rd); check("R9 status setup", rd, 8'h01);

    // R4 second byte not compared; no-start byte ignored
    pulse_start(); send(8'h10);
    check("R4 first miss", {7'b0, aas}, 8'h00);
    send(8'hAA);
    check("R4 later byte ignored", {7'b0, aas}, 8'h00);
    pulse_start(); send(8'hAA);
    check("R10 aas one edge later", {7'b0, aas}, 8'h01);
    send(8'h33);
    check("R4 later byte keeps aas", {7'b0, aas}, 8'h01);

    // R6 data read returns last byte and clears
    host_write(1'b1, 8'h00);
    host_read(1'b0, rd); check("R6 data value", rd, 8'h33);
    check("R6 read clears", {7'b0, aas}, 8'h00);

    // R6 set wins over read-clear in same cycle
    pulse_start();
    host_rd = 1; host_sel = 0; addr_valid = 1; addr_byte = 8'hAB;
    @(negedge clk); idle();
    check("R6 set wins", {7'b0, aas}, 8'h01);

    // R5 start with byte in same cycle: not compared, and clears
    bus_start = 1; addr_valid = 1; addr_byte = 8'hAA;
    @(negedge clk); idle();
    check("R5 start clears, byte skipped", {7'b0, aas}, 8'h00);
    send(8'hAA);
    check("R5 still armed after start", {7'b0, aas}, 8'h01);

    // R8 ready low during own write, byte not taken
    host_write(1'b1, 8'h01);
    pulse_start();
    host_wr = 1; host_sel = 0; host_wdata = 8'h22;
    addr_valid = 1; addr_byte = 8'h44;
    #1 check("R8 ready low", {7'b0, addr_ready}, 8'h00);
    @(negedge clk); idle();
    check("R8 no set on blocked byte", {7'b0, aas}, 8'h00);
    #1 check("R8 ready high", {7'b0, addr_ready}, 8'h01);
    send(8'h44);
    check("R8 armed byte taken later", {7'b0, aas}, 8'h01);

    // R7 monitor never claims
    host_write(1'b0, 8'h00);
    pulse_start(); send(8'h00);
    check("R7 no claim in monitor", {7'b0, aas}, 8'h00);
    host_read(1'b1, rd); check("R9 status monitor", rd, 8'h05);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule